// File: doc/BRIEF.md
# Trigger-Priority Side-Channel Scheduler

This block drives a narrow side channel that runs beside a serial data link. In every master clock cycle it places one 2-bit pair on that channel. Each symbol is 6 bits wide, so one symbol fills a 3-cycle slot. There are three symbols:

- a trigger marker;
- a frame-header marker;
- a sync filler that keeps the far end aligned to the master clock.

The slots follow one another without gaps from reset onwards, so the channel is never silent.

Triggers win every scheduling decision and appear with a fixed latency of one cycle. The latency holds only if the trigger pulse lands in the last cycle of a slot; a slot that has started always runs to its end. A header request from the frame builder is served only once the channel has carried no trigger pair for three consecutive cycles. The grant pulse comes in the last cycle of the header symbol, so the frame body can start in the very next cycle. A trigger pulse that comes less than three cycles after the previously accepted one is dropped, and an error pulse reports the drop.

Top module: `trig_side_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the channel shows the first pair of a sync slot (2'b10). In that cycle busy, hdrGrant and trigErr are all 0.
- R2: Symbol codes are: trigger 6'b111000, header 6'b000111, sync 6'b101010. Each code is sent over 3 consecutive cycles, bits [5:4] first, then [3:2], then [1:0].
- R3: A trigger pulse in the last cycle of a slot makes the first trigger pair (2'b11) appear in the very next cycle. Two triggers exactly 3 cycles apart both go out, back to back.
- R4: When a trigger pulse and an eligible header request coincide at a slot boundary, the trigger is sent. The header waits.
- R5: A header slot starts only if none of the 3 cycles before it carried a trigger pair. After a trigger slot, at least one sync slot passes before a header.
- R6: A trigger pulse in the first or second cycle of a trigger slot is dropped: no extra trigger slot follows it. trigErr is 1 in the cycle after that pulse. A trigger pulse in a non-final cycle of a sync or header slot is a usage error.
- R7: hdrGrant is a single-cycle pulse in the last cycle of a header slot. A request that is still high in its grant cycle does not start a second header in the slot that follows.
- R8: A sync slot is sent whenever no trigger and no eligible header is pending at a boundary. A slot that has begun is never cut short.
- R9: busy is 1 in exactly the cycles of trigger and header slots, and 0 during sync slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | One-cycle trigger pulse |
| hdrReq | input | 1 | Header request from the frame builder, held until granted |
| sideBits | output | PAIR_W | Side-channel pair for this cycle |
| hdrGrant | output | 1 | Pulse in the last cycle of a header symbol |
| busy | output | 1 | A trigger or header symbol is on the channel |
| trigErr | output | 1 | Pulse one cycle after a dropped trigger |

## Verification
On every cycle, the assertions check:
- a boundary trigger always opens a trigger slot;
- a slot never changes symbol before it ends;
- the first pair of every newly loaded symbol matches its code;
- headers start only after three trigger-free cycles;
- grants last one cycle;
- triggers arrive only at legal moments.

Only the bench's scenarios show the full pair sequence of each symbol, trigger priority over a waiting header, and the non-repeat of a header whose request is held across its grant. They also show that a dropped trigger leaves the channel unchanged. The bench runs a cycle model from the requirements alongside the design, through directed sequences and through sweeps of trigger and request densities.

// File: rtl/trig_side_pkg.sv
package trig_side_pkg;

  typedef enum logic [1:0] {
    SYM_SYN = 2'd0,
    SYM_TRG = 2'd1,
    SYM_HDR = 2'd2
  } sym_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // load a new symbol code at the slot boundary
    sym_e sel;      // symbol to load
    logic trgSlot;  // current slot carries a trigger
  } sched_strobe_t;

endpackage

// File: rtl/trig_side_dp.sv
module trig_side_dp
  import trig_side_pkg::*;
#(
  parameter int PAIR_W   = 2,
  parameter int SYM_W    = 6,
  parameter int FREE_MIN = 3,
  parameter logic [SYM_W-1:0] TRG_CODE = 6'b111000,
  parameter logic [SYM_W-1:0] HDR_CODE = 6'b000111,
  parameter logic [SYM_W-1:0] SYN_CODE = 6'b101010
) (
  input  logic              clk,
  input  logic              rstN,
  input  sched_strobe_t     ctl,
  output logic              hdrFree,
  output logic [PAIR_W-1:0] pairOut
);

  localparam int FREE_W = $clog2(FREE_MIN + 1);
  localparam logic [FREE_W-1:0] FREE_SAT = FREE_W'(FREE_MIN);

  logic [SYM_W-1:0]  shReg;
  logic [SYM_W-1:0]  codeSel;
  logic [FREE_W-1:0] freeCnt;
  logic [FREE_W-1:0] freeNow;

  always_comb begin
    case (ctl.sel)
      SYM_TRG: codeSel = TRG_CODE;
      SYM_HDR: codeSel = HDR_CODE;
      default: codeSel = SYN_CODE;
    endcase
  end

  // Symbol shift register: most significant pair leaves first
  always_ff @(posedge clk) begin
    if (!rstN)         shReg <= SYN_CODE;
    else if (ctl.load) shReg <= codeSel;
    else               shReg <= shReg << PAIR_W;
  end

  assign pairOut = shReg[SYM_W-1 -: PAIR_W];

  // Trigger-free cycle count, including the current cycle
  always_comb begin
    if (ctl.trgSlot)             freeNow = '0;
    else if (freeCnt >= FREE_SAT) freeNow = FREE_SAT;
    else                          freeNow = freeCnt + FREE_W'(1);
  end

  assign hdrFree = (freeNow >= FREE_SAT);

  always_ff @(posedge clk) begin
    if (!rstN) freeCnt <= '0;
    else       freeCnt <= freeNow;
  end

  // R2: the first pair after a load is the top pair of the chosen code
  a_r2_first_pair: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (pairOut == $past(codeSel[SYM_W-1 -: PAIR_W])));

  // R5: a header starts only after enough trigger-free cycles
  a_r5_hdr_gap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.sel == SYM_HDR) |-> (!ctl.trgSlot && freeCnt >= FREE_SAT - FREE_W'(1)));

endmodule

// File: rtl/trig_side_ctrl.sv
module trig_side_ctrl
  import trig_side_pkg::*;
#(
  parameter int PAIR_W = 2,
  parameter int SYM_W  = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigIn,
  input  logic          hdrReq,
  input  logic          hdrFree,
  output sched_strobe_t ctl,
  output logic          hdrGrant,
  output logic          busy,
  output logic          trigErr
);

  localparam int SLOT_LEN = SYM_W / PAIR_W;
  localparam int PH_W     = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOT_LEN - 1);

  logic [PH_W-1:0] ph;
  sym_e            curSym;
  sym_e            nextSym;
  logic            slotEnd;
  logic            grantNow;

  assign slotEnd  = (ph == LAST_PH);
  assign grantNow = slotEnd && (curSym == SYM_HDR);

  // Priority: trigger, then eligible header, then sync
  always_comb begin
    if (trigIn)                             nextSym = SYM_TRG;
    else if (hdrReq && !grantNow && hdrFree) nextSym = SYM_HDR;
    else                                    nextSym = SYM_SYN;
  end

  assign ctl.load    = slotEnd;
  assign ctl.sel     = nextSym;
  assign ctl.trgSlot = (curSym == SYM_TRG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ph      <= '0;
      curSym  <= SYM_SYN;
      trigErr <= 1'b0;
    end else begin
      trigErr <= trigIn && !slotEnd;
      if (slotEnd) begin
        ph     <= '0;
        curSym <= nextSym;
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end

  assign hdrGrant = grantNow;
  assign busy     = (curSym != SYM_SYN);

  // R3: a boundary trigger opens a trigger slot in the next cycle
  a_r3_trig_latency: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && slotEnd) |=> (curSym == SYM_TRG && ph == '0));

  // R8: a slot that has begun keeps its symbol to the end
  a_r8_no_cut: assert property (@(posedge clk) disable iff (!rstN)
    (ph != LAST_PH) |=> (curSym == $past(curSym)));

  // R6: triggers come only at a slot end or inside a trigger slot
  a_r6_trig_legal: assert property (@(posedge clk) disable iff (!rstN)
    trigIn |-> (slotEnd || curSym == SYM_TRG));

  // R6: a dropped trigger raises the error flag one cycle later
  a_r6_err_flag: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && !slotEnd) |=> trigErr);

  // R7: the grant lasts exactly one cycle
  a_r7_grant_single: assert property (@(posedge clk) disable iff (!rstN)
    hdrGrant |=> !hdrGrant);

endmodule

// File: rtl/trig_side_sched.sv
module trig_side_sched
  import trig_side_pkg::*;
#(
  parameter int PAIR_W   = 2,
  parameter int SYM_W    = 6,
  parameter int FREE_MIN = 3,
  parameter logic [SYM_W-1:0] TRG_CODE = 6'b111000,
  parameter logic [SYM_W-1:0] HDR_CODE = 6'b000111,
  parameter logic [SYM_W-1:0] SYN_CODE = 6'b101010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic              hdrReq,
  output logic [PAIR_W-1:0] sideBits,
  output logic              hdrGrant,
  output logic              busy,
  output logic              trigErr
);

  sched_strobe_t ctl;
  logic          hdrFree;

  trig_side_ctrl #(
    .PAIR_W(PAIR_W),
    .SYM_W (SYM_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .trigIn  (trigIn),
    .hdrReq  (hdrReq),
    .hdrFree (hdrFree),
    .ctl     (ctl),
    .hdrGrant(hdrGrant),
    .busy    (busy),
    .trigErr (trigErr)
  );

  trig_side_dp #(
    .PAIR_W  (PAIR_W),
    .SYM_W   (SYM_W),
    .FREE_MIN(FREE_MIN),
    .TRG_CODE(TRG_CODE),
    .HDR_CODE(HDR_CODE),
    .SYN_CODE(SYN_CODE)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .hdrFree(hdrFree),
    .pairOut(sideBits)
  );

endmodule

// File: tb/sim_trig_side_sched.sv
module sim_trig_side_sched;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic hdrReq = 1'b0;
  logic [1:0] sideBits;
  logic hdrGrant, busy, trigErr;

  always #5 clk = ~clk;

  trig_side_sched u0 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .hdrReq(hdrReq),
    .sideBits(sideBits), .hdrGrant(hdrGrant), .busy(busy), .trigErr(trigErr)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Cycle model built from the requirements: 0 sync, 1 trigger, 2 header
  int mPh = 0;
  int mSym = 0;
  int mFree = 0;
  bit mErr = 0;

  function automatic logic [1:0] mPair();
    logic [5:0] c;
    c = (mSym == 1) ? 6'b111000 : (mSym == 2) ? 6'b000111 : 6'b101010;
    return c[(5 - 2*mPh) -: 2];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmpModel();
    chk(sideBits == mPair(), "R2 R8 side pair", sideBits, mPair());
    chk(busy == (mSym != 0), "R9 busy", busy, int'(mSym != 0));
    chk(hdrGrant == (mSym == 2 && mPh == 2), "R7 grant", hdrGrant, int'(mSym == 2 && mPh == 2));
    chk(trigErr == mErr, "R6 error flag", trigErr, mErr);
  endtask

  task automatic modelNext(input bit t, input bit r);
    int fNow;
    bit g;
    g = (mSym == 2 && mPh == 2);
    fNow = (mSym == 1) ? 0 : ((mFree >= 3) ? 3 : mFree + 1);
    mErr = t && (mPh != 2);
    if (mPh == 2) begin
      mSym = t ? 1 : ((r && !g && fNow == 3) ? 2 : 0);
      mPh = 0;
    end else begin
      mPh++;
    end
    mFree = fNow;
  endtask

  task automatic step(input bit t, input bit r);
    trigIn = t;
    hdrReq = r;
    cmpModel();
    @(posedge clk);
    modelNext(t, r);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    bit req;
    lfsr = 16'hACE1;
    req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk(sideBits == 2'b10, "R1 reset pair", sideBits, 2);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(hdrGrant == 0, "R1 reset grant", hdrGrant, 0);
    chk(trigErr == 0, "R1 reset error", trigErr, 0);

    // R3 R4: trigger at slot end beats a waiting header
    step(0, 0); step(0, 0);
    step(1, 1);
    chk(sideBits == 2'b11, "R3 R4 trigger first pair", sideBits, 3);
    chk(busy == 1, "R9 busy in trigger", busy, 1);
    step(0, 1);
    chk(sideBits == 2'b10, "R2 trigger second pair", sideBits, 2);
    step(0, 1);
    chk(sideBits == 2'b00, "R2 trigger third pair", sideBits, 0);

    // R5: a sync slot must separate the trigger from the header
    step(0, 1);
    chk(sideBits == 2'b10, "R5 sync after trigger", sideBits, 2);
    chk(busy == 0, "R5 not busy after trigger", busy, 0);
    step(0, 1); step(0, 1);
    step(0, 1);
    chk(sideBits == 2'b00, "R5 header first pair", sideBits, 0);
    chk(busy == 1, "R9 busy in header", busy, 1);
    step(0, 1);
    chk(sideBits == 2'b01, "R2 header second pair", sideBits, 1);
    step(0, 1);
    chk(sideBits == 2'b11, "R2 header third pair", sideBits, 3);
    chk(hdrGrant == 1, "R7 grant at header end", hdrGrant, 1);

    // R7: request still high in the grant cycle gives no second header
    step(0, 1);
    chk(sideBits == 2'b10, "R7 no repeat header", sideBits, 2);
    chk(hdrGrant == 0, "R7 grant single", hdrGrant, 0);

    // R6: a close trigger is dropped and flagged
    step(0, 0); step(0, 0);
    step(1, 0);
    step(1, 0);
    chk(trigErr == 1, "R6 error after close trigger", trigErr, 1);
    chk(sideBits == 2'b10, "R6 trigger slot unchanged", sideBits, 2);
    step(0, 0);
    chk(trigErr == 0, "R6 error clears", trigErr, 0);
    step(0, 0);
    chk(sideBits == 2'b10, "R6 no extra trigger", sideBits, 2);

    // R3: triggers exactly 3 cycles apart both go out
    step(0, 0); step(0, 0);
    step(1, 0);
    step(0, 0); step(0, 0);
    step(1, 0);
    chk(sideBits == 2'b11, "R3 back to back trigger", sideBits, 3);
    chk(trigErr == 0, "R3 no error at 3 apart", trigErr, 0);

    // Sweep trigger densities against the cycle model
    for (int mode = 0; mode < 4; mode++) begin
      for (int cyc = 0; cyc < 1500; cyc++) begin
        bit t;
        bit g;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        t = 0;
        if (mPh == 2 && int'(lfsr[3:0]) < 2 + mode * 4) t = 1;
        else if (mSym == 1 && mPh != 2 && lfsr[7:4] == 4'd0) t = 1;
        if (!req && lfsr[11:8] < 4'd8) req = 1;
        g = (mSym == 2 && mPh == 2);
        step(t, req);
        if (g) req = 0;
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule